// File: doc/BRIEF.md
# Time-of-day alarm comparator

The comparator watches the seconds, minutes and hours fields of a running clock and checks them against three programmed alarm fields. The check runs only in the cycle in which the update strobe is high, which is the cycle after the clock fields have advanced. When all three fields agree, the block sets a sticky alarm flag. If the alarm enable is on, the same event also raises the alarm's interrupt contribution.

Any alarm field whose two top bits are both 1 is a wildcard and agrees with every value. Two mode inputs choose how the fields are encoded. One picks BCD or plain binary. The other picks a 24-hour or a 12-hour hour field. In 12-hour form, hour bit 7 marks PM and the hour is brought to a 0..23 value before it is compared. While the freeze input (the clock's set mode) is high, the clock is stopped and update strobes cause no comparison. Software acknowledges an event by pulsing the clear input, which represents the status-register read.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, both alm_flag and alm_irq are 0.
- R2: An alarm byte with bits 7:6 equal to 2'b11 is a wildcard, and its field matches any current value.
- R3: With bin_mode=0 (BCD), the field value is 10*bits[7:4] + bits[3:0]. For example, alarm 0x10 matches current 0x0A, and alarm 0x57 does not match current 0x56.
- R4: With bin_mode=1, the field value is the byte itself. For example, alarm 0x10 does not match current 0x0A, and alarm 0x3B matches current 0x3B.
- R5: With h24_mode=0, an hour byte is normalised as follows: value = decode(bits[6:0]); a value of 12 becomes 0; 12 is added when bit 7 is 1. Examples: 0x12 and 0x00 both give hour 0, 0x92 and 0x80 both give hour 12, and 0x12 does not match 0x92. With h24_mode=1, the hour byte is decoded unchanged, so 0x12 does not match 0x00.
- R6: With all three alarm bytes set to wildcards, every update strobe taken while freeze=0 sets the flag.
- R7: A match in a cycle with upd_stb=1 and freeze=0 sets alm_flag one clock later. Without upd_stb, the flag never changes from 0 to 1.
- R8: alm_irq is raised together with the flag only when alm_ie=1 in the match cycle. With alm_ie=0, the flag is set and alm_irq stays 0.
- R9: While freeze=1, update strobes are ignored and no match is recorded.
- R10: The flag is sticky. A match while the flag is already set raises no new alm_irq. flag_clr clears both outputs on the next clock.
- R11: If flag_clr and a match fall in the same cycle, the match wins. The flag is 1 afterwards, and alm_irq follows alm_ie.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_stb | input | 1 | One-cycle update strobe; the time fields have already advanced |
| freeze | input | 1 | Set mode: clock stopped, strobes ignored |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour hour field, 0 = 12-hour with PM in bit 7 |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds (11xxxxxx = wildcard) |
| alm_min | input | 8 | Alarm minutes (11xxxxxx = wildcard) |
| alm_hour | input | 8 | Alarm hours (11xxxxxx = wildcard) |
| alm_ie | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Acknowledge: clears flag and interrupt |
| alm_flag | output | 1 | Sticky alarm flag |
| alm_irq | output | 1 | Alarm interrupt contribution |

## Verification
The first patterns are matching and non-matching times in BCD. After them, the same byte pair 0x10/0x0A is applied in both encodings, so a wrong decoder gives the wrong result in one of the two modes. The hour tests use byte pairs that are equal only after 12-hour normalisation (0x12 against 0x00, 0x92 against 0x80) and a pair that differs only in the PM bit. The same 0x12/0x00 pair is then repeated in 24-hour mode. Further sequences cover wildcard-only alarms across changing times, enable on and off, a strobe while frozen, match inputs held without a strobe, and a clear that coincides with a match. These separate the sticky, ignore and priority rules.

// File: rtl/alarm_cmp.sv
module alarm_cmp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_stb,
  input  logic       freeze,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic       alm_ie,
  input  logic       flag_clr,
  output logic       alm_flag,
  output logic       alm_irq
);

  function automatic logic [7:0] dec(input logic [7:0] v, input logic bin);
    dec = bin ? v : ({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]});
  endfunction

  function automatic logic [7:0] hnorm(input logic [7:0] v, input logic bin,
                                       input logic h24);
    logic [7:0] raw;
    logic [7:0] base;
    raw  = dec({1'b0, v[6:0]}, bin);
    base = (raw == 8'd12) ? 8'd0 : raw;
    hnorm = h24 ? dec(v, bin) : (base + (v[7] ? 8'd12 : 8'd0));
  endfunction

  logic sec_ok, min_ok, hour_ok, hit;

  assign sec_ok  = (&alm_sec[7:6])  || (dec(cur_sec, bin_mode) == dec(alm_sec, bin_mode));
  assign min_ok  = (&alm_min[7:6])  || (dec(cur_min, bin_mode) == dec(alm_min, bin_mode));
  assign hour_ok = (&alm_hour[7:6]) ||
                   (hnorm(cur_hour, bin_mode, h24_mode) == hnorm(alm_hour, bin_mode, h24_mode));
  assign hit     = upd_stb && !freeze && sec_ok && min_ok && hour_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_flag <= 1'b0;
      alm_irq  <= 1'b0;
    end else begin
      alm_flag <= (alm_flag && !flag_clr) || hit;
      alm_irq  <= (alm_irq && !flag_clr) || (hit && alm_ie && (!alm_flag || flag_clr));
    end
  end

endmodule

module alarm_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_stb,
  input logic       freeze,
  input logic [7:0] alm_sec,
  input logic [7:0] alm_min,
  input logic [7:0] alm_hour,
  input logic       alm_ie,
  input logic       flag_clr,
  input logic       alm_flag,
  input logic       alm_irq
);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alm_irq |-> alm_flag);

  a_r8_no_irq_without_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_ie && !alm_irq) |=> !alm_irq);

  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !flag_clr) |=> (alm_flag == $past(alm_flag)) && (alm_irq == $past(alm_irq)));

  a_r7_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_stb && !flag_clr) |=> $stable(alm_flag) && $stable(alm_irq));

  a_r10_no_new_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !alm_irq && !flag_clr) |=> !alm_irq);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(upd_stb && !freeze)) |=> !alm_flag && !alm_irq);

  a_r6_all_wild: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !freeze && (&alm_sec[7:6]) && (&alm_min[7:6]) && (&alm_hour[7:6])) |=> alm_flag);

endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .freeze(freeze),
  .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
  .alm_ie(alm_ie), .flag_clr(flag_clr), .alm_flag(alm_flag), .alm_irq(alm_irq)
);

// File: tb/tb_alarm_cmp.sv
module tb_alarm_cmp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_stb = 1'b0, freeze = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] alm_sec = 8'h01, alm_min = 8'h01, alm_hour = 8'h01;
  logic alm_ie = 1'b0, flag_clr = 1'b0;
  logic alm_flag, alm_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int m_flag = 0;
  int m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_cmp dut (.*);

  function automatic int fval(logic [7:0] b, logic bin);
    if (bin) return int'(b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int hval(logic [7:0] b, logic bin, logic h24);
    int h;
    if (h24) return fval(b, bin);
    h = fval(b & 8'h7F, bin);
    if (h == 12) h = 0;
    if (b[7]) h += 12;
    return h;
  endfunction

  function automatic bit fmatch(logic [7:0] a, int cv, int av);
    return (a[7:6] == 2'b11) || (cv == av);
  endfunction

  always @(posedge clk) begin
    bit hit;
    if (!rst_n) begin
      m_flag = 0;
      m_irq = 0;
    end else begin
      hit = upd_stb && !freeze &&
            fmatch(alm_sec, fval(cur_sec, bin_mode), fval(alm_sec, bin_mode)) &&
            fmatch(alm_min, fval(cur_min, bin_mode), fval(alm_min, bin_mode)) &&
            fmatch(alm_hour, hval(cur_hour, bin_mode, h24_mode), hval(alm_hour, bin_mode, h24_mode));
      if (flag_clr) begin
        m_flag = 0;
        m_irq = 0;
        if (hit) begin m_flag = 1; m_irq = alm_ie ? 1 : 0; end
      end else if (hit) begin
        if (m_flag == 0 && alm_ie) m_irq = 1;
        m_flag = 1;
      end
    end
  end

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n) begin
      total++;
      if (int'(alm_flag) != m_flag) begin
        bad++;
        $display("FAIL R7 per-cycle flag actual=%0d expected=%0d", alm_flag, m_flag);
      end
      total++;
      if (int'(alm_irq) != m_irq) begin
        bad++;
        $display("FAIL R8 per-cycle irq actual=%0d expected=%0d", alm_irq, m_irq);
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_t(logic [7:0] cs, logic [7:0] cm, logic [7:0] ch,
                       logic [7:0] as, logic [7:0] am, logic [7:0] ah);
    cur_sec = cs; cur_min = cm; cur_hour = ch;
    alm_sec = as; alm_min = am; alm_hour = ah;
  endtask

  task automatic strobe();
    @(negedge clk);
    upd_stb = 1'b1;
    @(negedge clk);
    upd_stb = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", alm_flag, 1'b0);
    chk("R1 irq after reset", alm_irq, 1'b0);

    alm_ie = 1'b1;
    set_t(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12);
    strobe();
    chk("R3 bcd match flag", alm_flag, 1'b1);
    chk("R8 irq with enable", alm_irq, 1'b1);
    clear();
    chk("R10 clear flag", alm_flag, 1'b0);
    chk("R10 clear irq", alm_irq, 1'b0);

    set_t(8'h56, 8'h34, 8'h12, 8'h57, 8'h34, 8'h12);
    strobe();
    chk("R3 bcd mismatch", alm_flag, 1'b0);

    set_t(8'h21, 8'h34, 8'h12, 8'hC0, 8'h34, 8'h12);
    strobe();
    chk("R2 wildcard seconds", alm_flag, 1'b1);
    clear();

    alm_ie = 1'b0;
    set_t(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12);
    strobe();
    chk("R8 flag without enable", alm_flag, 1'b1);
    chk("R8 no irq without enable", alm_irq, 1'b0);
    alm_ie = 1'b1;
    strobe();
    chk("R10 sticky flag", alm_flag, 1'b1);
    chk("R10 no new irq while set", alm_irq, 1'b0);
    clear();

    set_t(8'h0A, 8'h05, 8'h03, 8'h10, 8'h05, 8'h03);
    strobe();
    chk("R3 bcd 0x10 vs 0x0A", alm_flag, 1'b1);
    clear();
    bin_mode = 1'b1;
    strobe();
    chk("R4 binary 0x10 vs 0x0A", alm_flag, 1'b0);
    set_t(8'h3B, 8'h2A, 8'h17, 8'h3B, 8'h2A, 8'h17);
    strobe();
    chk("R4 binary match", alm_flag, 1'b1);
    clear();
    bin_mode = 1'b0;

    h24_mode = 1'b0;
    set_t(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12);
    strobe();
    chk("R5 12h midnight 0x12 vs 0x00", alm_flag, 1'b1);
    clear();
    set_t(8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h92);
    strobe();
    chk("R5 12h noon 0x92 vs 0x80", alm_flag, 1'b1);
    clear();
    set_t(8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12);
    strobe();
    chk("R5 12h pm bit differs", alm_flag, 1'b0);
    h24_mode = 1'b1;
    set_t(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12);
    strobe();
    chk("R5 24h 0x12 vs 0x00", alm_flag, 1'b0);

    for (int i = 0; i < 4; i++) begin
      set_t(8'(i * 7), 8'(i * 3), 8'(i), 8'hC0, 8'hFF, 8'hC5);
      strobe();
      chk("R6 all wildcard fires", alm_flag, 1'b1);
      clear();
    end

    freeze = 1'b1;
    set_t(8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h10);
    strobe();
    chk("R9 frozen strobe ignored", alm_flag, 1'b0);
    chk("R9 frozen no irq", alm_irq, 1'b0);
    freeze = 1'b0;

    repeat (5) @(negedge clk);
    chk("R7 no strobe no flag", alm_flag, 1'b0);
    strobe();
    chk("R7 strobe sets flag", alm_flag, 1'b1);

    @(negedge clk);
    flag_clr = 1'b1;
    upd_stb = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    upd_stb = 1'b0;
    chk("R11 match beats clear flag", alm_flag, 1'b1);
    chk("R11 match beats clear irq", alm_irq, 1'b1);
    clear();

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule